// File: doc/BRIEF.md
# System Register Access Permission Gate

This block decides what happens when software reads or writes one control-mask system register. The request gives the register's five-field encoding, the privilege level it comes from, and a set of configuration inputs: feature present, level-3 present, the level-3 enable for this register, the level-3 undefined-priority and undefined-select conditions, level 2 enabled, fine-grained trap support and its level-3 enable, separate read and write fine-grained allow bits, the extended-control state and its enable, the three nested-virtualization bits, and host mode. The decision is one of six outcomes. The access can go to the level-1 copy of the register or to the level-2 copy. It can be redirected to a memory offset, trapped to level 2, trapped to level 3, or treated as undefined.

The block holds no register data and performs no memory access. It issues a verdict one cycle after each request strobe. The verdict has a result code, the trap target level, a syndrome class and the redirect offset. A two-state machine drives the response strobe. State `ST_IDLE` moves to `ST_SHOW` on `req_valid`. `ST_SHOW` stays in `ST_SHOW` on another `req_valid` and returns to `ST_IDLE` without one. `rsp_valid` is high exactly in `ST_SHOW`.

Top module: `sreg_gate`

## Requirements
- R1: `rsp_valid` is high in the cycle after every cycle where `req_valid` is high, and low otherwise. The verdict outputs load only on a request and otherwise keep their value.
- R2: When the feature is absent, or the request comes from level 0, the code is 5 (undefined).
- R3: The main encoding is op0=3, op1=0, crn=1, crm=4, op2=0. The alias encoding is the same with op1=5. Any other encoding gives code 5.
- R4: At level 1 on the main encoding, the conditions are tested in priority order, and the first one that holds decides the code:
  - level 3 present with undefined-priority set and its enable clear gives code 5;
  - level 2 enabled with fine-grained support, and either level 3 present with its fine-grained enable clear or the allow bit at 0, gives code 3;
  - level 2 enabled with the extended control off or its enable at 0 gives code 3;
  - level 3 present with its enable clear gives code 5 if undefined-select is set, else code 4;
  - nested bits equal to 111 give code 2;
  - otherwise the code is 0.
- R5: Code 2 (redirect) reports offset 0x318. Every other code reports offset 0.
- R6: At level 1 on the alias encoding, nested bits 101 give code 2. Any other value with bit 0 set gives code 3. All remaining values give code 5.
- R7: At level 2 on the main encoding, the two level-3 checks of R4 come first. If neither applies, the code is 1 in host mode and 0 otherwise.
- R8: At level 2 on the alias encoding, host mode off gives code 5. With host mode on, the R4 level-3 checks come first and the code is 0 otherwise.
- R9: At level 3, the main encoding gives code 0. The alias encoding gives code 0 in host mode and code 5 otherwise.
- R10: Code 3 reports target 2 and code 4 reports target 3, both with class 0x18. Every other code reports target 0 and class 0.
- R11: A read uses `fg_read_ok` as the fine-grained allow bit and a write uses `fg_write_ok`. The other bit has no effect.
- R12: After reset, `rsp_valid` is 0, the code is 5, and target, class and offset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| cur_level | input | 2 | Privilege level of the request (0 to 3) |
| feat_present | input | 1 | Mask register feature implemented |
| l3_present | input | 1 | Level 3 implemented |
| l3_undef_prio | input | 1 | Level-3 undefined-priority condition active |
| l3_mask_en | input | 1 | Level-3 enable for this register |
| l3_undef_sel | input | 1 | Level-3 block gives undefined instead of trap |
| l2_enabled | input | 1 | Level 2 enabled |
| fgt2_present | input | 1 | Second fine-grained trap set implemented |
| l3_fgt_en | input | 1 | Level-3 enable for fine-grained traps |
| fg_read_ok | input | 1 | Fine-grained allow bit for reads (0 traps) |
| fg_write_ok | input | 1 | Fine-grained allow bit for writes (0 traps) |
| xctl_enabled | input | 1 | Extended level-2 control active |
| xctl_mask_en | input | 1 | Extended-control enable for this register |
| nv_bits | input | 3 | Nested-virtualization bits {bit2,bit1,bit0} |
| host_mode | input | 1 | Level 2 runs as host |
| rsp_valid | output | 1 | Verdict valid |
| rsp_code | output | 3 | Verdict code (0 to 5) |
| rsp_target | output | 2 | Trap target level |
| rsp_class | output | 6 | Syndrome class |
| rsp_offset | output | 12 | Redirect offset |

## Verification
A new request can arrive in the same cycle that the verdict for the previous request is shown. The sweep drives one request in every cycle without gaps, so the bench must read verdict N while request N+1 is being loaded. Each verdict is sampled at the falling edge after its request and compared with the model value computed for that request. A drop of the strobe after the run is then checked to show the last verdict held with `rsp_valid` low.

// File: rtl/sreg_gate_pkg.sv
package sreg_gate_pkg;

    typedef enum logic [2:0] {
        RES_ACC_L1  = 3'd0,
        RES_ACC_L2  = 3'd1,
        RES_REDIR   = 3'd2,
        RES_TRAP_L2 = 3'd3,
        RES_TRAP_L3 = 3'd4,
        RES_UNDEF   = 3'd5
    } res_e;

    typedef enum logic [1:0] {
        ENC_NONE    = 2'd0,
        ENC_PRIMARY = 2'd1,
        ENC_ALIAS   = 2'd2
    } enc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } gate_st_e;

    typedef struct packed {
        logic feat;
        logic l3_present;
        logic l3_undef_prio;
        logic l3_mask_en;
        logic l3_undef_sel;
        logic l2_en;
        logic fgt2;
        logic l3_fgt_en;
        logic fg_allow;
        logic xctl_en;
        logic xctl_mask_en;
        logic host;
    } cfg_t;

endpackage

// File: rtl/sreg_gate_decode.sv
module sreg_gate_decode
    import sreg_gate_pkg::*;
#(
    parameter logic [1:0] P_OP0       = 2'b11,
    parameter logic [2:0] P_OP1_MAIN  = 3'b000,
    parameter logic [2:0] P_OP1_ALIAS = 3'b101,
    parameter logic [3:0] P_CRN       = 4'b0001,
    parameter logic [3:0] P_CRM       = 4'b0100,
    parameter logic [2:0] P_OP2       = 3'b000
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output enc_e       enc
);
    logic common_hit;

    always_comb begin
        common_hit = (op0 == P_OP0) && (crn == P_CRN) && (crm == P_CRM) && (op2 == P_OP2);
        enc = ENC_NONE;
        if (common_hit && (op1 == P_OP1_MAIN))
            enc = ENC_PRIMARY;
        else if (common_hit && (op1 == P_OP1_ALIAS))
            enc = ENC_ALIAS;
    end
endmodule

// File: rtl/sreg_gate_resolve.sv
module sreg_gate_resolve
    import sreg_gate_pkg::*;
(
    input  enc_e       enc,
    input  logic [1:0] level,
    input  cfg_t       cfg,
    input  logic [2:0] nv,
    output res_e       res
);
    logic l3_early;
    logic l3_block;
    res_e l3_res;
    logic fg_trap;
    logic xctl_trap;

    always_comb begin
        l3_early  = cfg.l3_present && cfg.l3_undef_prio && !cfg.l3_mask_en;
        l3_block  = cfg.l3_present && !cfg.l3_mask_en;
        l3_res    = cfg.l3_undef_sel ? RES_UNDEF : RES_TRAP_L3;
        fg_trap   = cfg.l2_en && cfg.fgt2 &&
                    ((cfg.l3_present && !cfg.l3_fgt_en) || !cfg.fg_allow);
        xctl_trap = cfg.l2_en && (!cfg.xctl_en || !cfg.xctl_mask_en);
        res       = RES_UNDEF;

        if (cfg.feat && (enc != ENC_NONE)) begin
            unique case (level)
                2'd0: res = RES_UNDEF;
                2'd1: begin
                    if (enc == ENC_PRIMARY) begin
                        if (l3_early)          res = RES_UNDEF;
                        else if (fg_trap)      res = RES_TRAP_L2;
                        else if (xctl_trap)    res = RES_TRAP_L2;
                        else if (l3_block)     res = l3_res;
                        else if (nv == 3'b111) res = RES_REDIR;
                        else                   res = RES_ACC_L1;
                    end else begin
                        if (nv == 3'b101)      res = RES_REDIR;
                        else if (nv[0])        res = RES_TRAP_L2;
                        else                   res = RES_UNDEF;
                    end
                end
                2'd2: begin
                    if (enc == ENC_ALIAS && !cfg.host) res = RES_UNDEF;
                    else if (l3_early)                 res = RES_UNDEF;
                    else if (l3_block)                 res = l3_res;
                    else if (enc == ENC_PRIMARY && cfg.host) res = RES_ACC_L2;
                    else                               res = RES_ACC_L1;
                end
                2'd3: begin
                    if (enc == ENC_PRIMARY || cfg.host) res = RES_ACC_L1;
                    else                                res = RES_UNDEF;
                end
                default: res = RES_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/sreg_gate.sv
module sreg_gate
    import sreg_gate_pkg::*;
#(
    parameter int              CLASS_W      = 6,
    parameter int              OFFSET_W     = 12,
    parameter logic [5:0]      TRAP_CLASS   = 6'h18,
    parameter logic [11:0]     REDIR_OFFSET = 12'h318
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          op0,
    input  logic [2:0]          op1,
    input  logic [3:0]          crn,
    input  logic [3:0]          crm,
    input  logic [2:0]          op2,
    input  logic [1:0]          cur_level,
    input  logic                feat_present,
    input  logic                l3_present,
    input  logic                l3_undef_prio,
    input  logic                l3_mask_en,
    input  logic                l3_undef_sel,
    input  logic                l2_enabled,
    input  logic                fgt2_present,
    input  logic                l3_fgt_en,
    input  logic                fg_read_ok,
    input  logic                fg_write_ok,
    input  logic                xctl_enabled,
    input  logic                xctl_mask_en,
    input  logic [2:0]          nv_bits,
    input  logic                host_mode,
    output logic                rsp_valid,
    output logic [2:0]          rsp_code,
    output logic [1:0]          rsp_target,
    output logic [CLASS_W-1:0]  rsp_class,
    output logic [OFFSET_W-1:0] rsp_offset
);
    localparam logic [CLASS_W-1:0]  CLASS_V  = CLASS_W'(TRAP_CLASS);
    localparam logic [OFFSET_W-1:0] OFFSET_V = OFFSET_W'(REDIR_OFFSET);

    enc_e     enc;
    cfg_t     cfg;
    res_e     res;
    gate_st_e state_q, state_d;

    assign cfg = '{feat:         feat_present,
                   l3_present:   l3_present,
                   l3_undef_prio:l3_undef_prio,
                   l3_mask_en:   l3_mask_en,
                   l3_undef_sel: l3_undef_sel,
                   l2_en:        l2_enabled,
                   fgt2:         fgt2_present,
                   l3_fgt_en:    l3_fgt_en,
                   fg_allow:     req_write ? fg_write_ok : fg_read_ok,
                   xctl_en:      xctl_enabled,
                   xctl_mask_en: xctl_mask_en,
                   host:         host_mode};

    sreg_gate_decode u_dec (
        .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2), .enc(enc)
    );

    sreg_gate_resolve u_res (
        .enc(enc), .level(cur_level), .cfg(cfg), .nv(nv_bits), .res(res)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = req_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rsp_valid = (state_q == ST_SHOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_code   <= RES_UNDEF;
            rsp_target <= 2'd0;
            rsp_class  <= '0;
            rsp_offset <= '0;
        end else if (req_valid) begin
            rsp_code   <= res;
            rsp_target <= (res == RES_TRAP_L2) ? 2'd2 : (res == RES_TRAP_L3) ? 2'd3 : 2'd0;
            rsp_class  <= (res == RES_TRAP_L2 || res == RES_TRAP_L3) ? CLASS_V : '0;
            rsp_offset <= (res == RES_REDIR) ? OFFSET_V : '0;
        end
    end
endmodule

// File: rtl/sreg_gate_chk.sv
module sreg_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  op0,
    input logic [2:0]  op1,
    input logic [3:0]  crn,
    input logic [3:0]  crm,
    input logic [2:0]  op2,
    input logic [1:0]  cur_level,
    input logic        feat_present,
    input logic        rsp_valid,
    input logic [2:0]  rsp_code,
    input logic [1:0]  rsp_target,
    input logic [5:0]  rsp_class,
    input logic [11:0] rsp_offset
);
    // R1
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_code)));
    // R2
    absent_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!feat_present || cur_level == 2'd0)) |=> (rsp_code == 3'd5));
    // R9
    top_level_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_present && cur_level == 2'd3 && op0 == 2'b11 && op1 == 3'b000
         && crn == 4'b0001 && crm == 4'b0100 && op2 == 3'b000) |=> (rsp_code == 3'd0));
    // R10
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == 3'd3 || rsp_code == 3'd4) |-> (rsp_class == 6'h18 && rsp_target != 2'd0));
    // R5
    offset_only_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != 3'd2) |-> (rsp_offset == 12'h000));
endmodule

bind sreg_gate sreg_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .cur_level(cur_level), .feat_present(feat_present),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_target(rsp_target),
    .rsp_class(rsp_class), .rsp_offset(rsp_offset)
);

// File: tb/sim_sreg_gate.sv
`timescale 1ns/1ps
module sim_sreg_gate;
    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] op0 = 2'b11;
    logic [2:0] op1 = 3'b000;
    logic [3:0] crn = 4'b0001, crm = 4'b0100;
    logic [2:0] op2 = 3'b000;
    logic [1:0] cur_level = 0;
    logic feat_present = 1, l3_present = 0, l3_undef_prio = 0, l3_mask_en = 0, l3_undef_sel = 0;
    logic l2_enabled = 0, fgt2_present = 0, l3_fgt_en = 0, fg_read_ok = 0, fg_write_ok = 0;
    logic xctl_enabled = 0, xctl_mask_en = 0, host_mode = 0;
    logic [2:0] nv_bits = 0;
    logic rsp_valid;
    logic [2:0] rsp_code;
    logic [1:0] rsp_target;
    logic [5:0] rsp_class;
    logic [11:0] rsp_offset;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sreg_gate u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of R2..R9 for main (alias=0) or alias (alias=1) encoding
    function automatic int model(input bit alias_e, input int lvl, input bit wr,
                                 input bit feat, input bit l3p, input bit up, input bit l3e,
                                 input bit usel, input bit l2e, input bit fg2, input bit l3fg,
                                 input bit frd, input bit fwr, input bit xe, input bit xb,
                                 input int nv, input bit host);
        bit allow = wr ? fwr : frd;
        bit early = l3p & up & ~l3e;
        bit blk   = l3p & ~l3e;
        int blkres = usel ? 5 : 4;
        if (!feat || lvl == 0) return 5;
        if (lvl == 1) begin
            if (alias_e) return (nv == 5) ? 2 : ((nv % 2) == 1) ? 3 : 5;
            if (early) return 5;
            if (l2e && fg2 && ((l3p && !l3fg) || !allow)) return 3;
            if (l2e && (!xe || !xb)) return 3;
            if (blk) return blkres;
            return (nv == 7) ? 2 : 0;
        end
        if (lvl == 2) begin
            if (alias_e && !host) return 5;
            if (early) return 5;
            if (blk) return blkres;
            return (!alias_e && host) ? 1 : 0;
        end
        return (!alias_e || host) ? 0 : 5;
    endfunction

    task automatic check_all(input int exp);
        chk("R1 valid", int'(rsp_valid), 1);
        chk("R4-chain code", int'(rsp_code), exp);
        chk("R10 target", int'(rsp_target), exp == 3 ? 2 : exp == 4 ? 3 : 0);
        chk("R10 class", int'(rsp_class), (exp == 3 || exp == 4) ? 24 : 0);
        chk("R5 offset", int'(rsp_offset), exp == 2 ? 12'h318 : 0);
    endtask

    initial begin
        #(4 * 180000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int exp_prev = 0;
        int last_code;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 valid", int'(rsp_valid), 0);
        chk("R12 code", int'(rsp_code), 5);
        chk("R12 target", int'(rsp_target), 0);
        chk("R12 class", int'(rsp_class), 0);
        chk("R12 offset", int'(rsp_offset), 0);
        rst_n = 1;
        @(negedge clk);

        // Back-to-back sweep; R4 R6 R7 R8 R9 R11 named in model
        for (int i = 0; i < 131072; i++) begin
            bit a = i[2], w = i[3], fb = i[14];
            if (i > 0) check_all(exp_prev);
            cur_level = i[1:0]; op1 = a ? 3'b101 : 3'b000; req_write = w;
            nv_bits = i[6:4]; host_mode = i[7]; l3_present = i[8];
            l3_undef_prio = i[9]; l3_mask_en = i[10]; l2_enabled = i[11];
            fgt2_present = i[12]; l3_fgt_en = i[13];
            fg_read_ok = w ? ~fb : fb; fg_write_ok = w ? fb : ~fb; // R11
            xctl_enabled = i[15]; xctl_mask_en = i[16];
            l3_undef_sel = i[16] ^ i[7] ^ i[4];
            req_valid = 1;
            exp_prev = model(a, int'(i[1:0]), w, 1'b1, i[8], i[9], i[10], l3_undef_sel,
                             i[11], i[12], i[13], fg_read_ok, fg_write_ok, i[15], i[16],
                             int'(i[6:4]), i[7]);
            @(negedge clk);
        end
        check_all(exp_prev);
        last_code = int'(rsp_code);
        req_valid = 0;
        @(negedge clk);
        // R1 hold with no request
        chk("R1 idle valid", int'(rsp_valid), 0);
        chk("R1 hold code", int'(rsp_code), last_code);

        // R2 feature absent at level 3 main
        l3_present = 0; host_mode = 1; nv_bits = 0;
        feat_present = 0; cur_level = 3; op1 = 0; req_valid = 1;
        @(negedge clk); req_valid = 0;
        chk("R2 absent", int'(rsp_code), 5);
        // R3 bad crm at level 3
        feat_present = 1; crm = 4'b0101; req_valid = 1;
        @(negedge clk); req_valid = 0;
        chk("R3 bad crm", int'(rsp_code), 5);
        // R3 bad op0
        crm = 4'b0100; op0 = 2'b10; req_valid = 1;
        @(negedge clk); req_valid = 0;
        chk("R3 bad op0", int'(rsp_code), 5);
        // R3 bad op1 (neither main nor alias)
        op0 = 2'b11; op1 = 3'b100; req_valid = 1;
        @(negedge clk); req_valid = 0;
        chk("R3 bad op1", int'(rsp_code), 5);
        // R9 good encoding restored
        op1 = 3'b000; req_valid = 1;
        @(negedge clk); req_valid = 0;
        chk("R9 main at level 3", int'(rsp_code), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule